// File: doc/BRIEF.md
# YCbCr to RGB888 Pixel Converter

The block turns a stream of 8-bit luma/chroma sample triples into 8-bit red, green and blue values. Each input first has an offset removed (one programmable offset for luma, one shared by both chroma samples). Five programmable unsigned coefficients, in units of 1/1024, then weight the three signed differences. Luma uses a single coefficient that is common to all three colours. Red adds one red-difference term and blue adds one blue-difference term. Green subtracts one blue-difference term and one red-difference term. Every sum is divided by 1024 and clipped to the 8-bit range. The output is always 8 bits per colour, whatever layout the samples were fetched from.

Pixels move through three registered stages: offset removal, multiply, then sum with clip. Both ends use a valid/ready handshake, and a new pixel can enter on every clock while the consumer keeps accepting. After reset the block holds a studio-swing standard-definition coefficient set. Software may load a different set, but only while no pixel is in flight, so one set of coefficients applies to a whole frame.

Top module: `ycc_to_rgb`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `in_ready_o` is 1. The coefficients are k0=0x4A8, k1=0x662, k2=0x191, k3=0x341 and k4=0x811. The luma offset is 0 and the chroma offset is 128.
- R2: The datapath forms yd = Y - luma_offset, cbd = Cb - chroma_offset and crd = Cr - chroma_offset as signed values before any multiplication.
- R3: Red = (k0*yd + k1*crd) >>> 10, where the shift is arithmetic and rounds toward minus infinity.
- R4: Green = (k0*yd - k2*cbd - k3*crd) >>> 10.
- R5: Blue = (k0*yd + k4*cbd) >>> 10.
- R6: Each colour result below 0 is output as 0, and each result above 255 is output as 255.
- R7: A pixel is accepted on a rising edge where `in_valid_i` and `in_ready_o` are both 1. Its result drives `out_valid_o` high from the second rising edge after the accepting edge. With `out_ready_i` held at 1, one pixel is accepted and one is delivered on every cycle.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, the outputs hold their values. Every accepted pixel is delivered exactly once, in order.
- R9: A write is `cfg_we_i`=1 at a rising edge. `cfg_sel_i` 0 to 4 loads k0 to k4 from `cfg_data_i[11:0]`. Select 5 loads the luma offset and select 6 loads the chroma offset, each from `cfg_data_i[7:0]`. Select 7 changes nothing. A loaded value applies to every pixel accepted afterwards.
- R10: A write is ignored while any pixel is held in any of the three stages. `in_ready_o` is 0 in every cycle in which `cfg_we_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel present |
| in_ready_o | output | 1 | Block can take a pixel |
| y_i | input | 8 | Luma sample |
| cb_i | input | 8 | Blue-difference sample |
| cr_i | input | 8 | Red-difference sample |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| r_o | output | 8 | Red |
| g_o | output | 8 | Green |
| b_o | output | 8 | Blue |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration target select |
| cfg_data_i | input | 12 | Configuration write value |

## Verification
A pixel accepted at rising edge n raises `out_valid_o` at edge n+2. It stays there until an edge where `out_ready_i` is 1. The scoreboard stores, with each expected colour triple, the cycle in which the pixel was accepted. In unstalled bursts it requires the result to appear exactly two cycles later. Under random backpressure it checks only order, values and that held outputs stay stable. All sampling happens after the falling edge, once the registered outputs have settled. Configuration writes are modelled one edge after their strobe, and only when the bench knows the pipeline to be empty.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int CFG_SEL_W = 3;

  typedef enum logic [CFG_SEL_W-1:0] {
    SEL_K0       = 3'd0,
    SEL_K1       = 3'd1,
    SEL_K2       = 3'd2,
    SEL_K3       = 3'd3,
    SEL_K4       = 3'd4,
    SEL_LUMA_OFS = 3'd5,
    SEL_CHR_OFS  = 3'd6,
    SEL_NONE     = 3'd7
  } cfg_sel_e;

  localparam int DEF_LUMA_OFS = 0;
  localparam int DEF_CHR_OFS  = 128;

  // reset coefficient set, units of 1/1024
  function automatic int def_coef(input int idx);
    case (idx)
      0:       return 'h4A8;
      1:       return 'h662;
      2:       return 'h191;
      3:       return 'h341;
      default: return 'h811;
    endcase
  endfunction
endpackage

// File: rtl/ycc_cfg_regs.sv
module ycc_cfg_regs
  import ycc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12,
  parameter int NCOEF  = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [CFG_SEL_W-1:0]          sel_i,
  input  logic [COEF_W-1:0]             data_i,
  output logic [NCOEF-1:0][COEF_W-1:0]  coef_o,
  output logic [PIX_W-1:0]              luma_ofs_o,
  output logic [PIX_W-1:0]              chr_ofs_o
);
  for (genvar k = 0; k < NCOEF; k++) begin : g_coef
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        coef_o[k] <= COEF_W'(def_coef(k));
      else if (wr_en_i && sel_i == CFG_SEL_W'(k))
        coef_o[k] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      luma_ofs_o <= PIX_W'(DEF_LUMA_OFS);
      chr_ofs_o  <= PIX_W'(DEF_CHR_OFS);
    end else if (wr_en_i) begin
      if (sel_i == SEL_LUMA_OFS) luma_ofs_o <= data_i[PIX_W-1:0];
      if (sel_i == SEL_CHR_OFS)  chr_ofs_o  <= data_i[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/ycc_pipe_ctrl.sv
module ycc_pipe_ctrl #(
  parameter int NSTAGE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              out_ready_i,
  output logic              in_ready_o,
  output logic [NSTAGE-1:0] load_o,
  output logic [NSTAGE-1:0] vld_o
);
  logic [NSTAGE-1:0] vld_q, rdy, feed;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign feed[k] = in_valid_i;
    end else begin : g_body
      assign feed[k] = vld_q[k-1];
    end
    if (k == NSTAGE - 1) begin : g_tail
      assign rdy[k] = ~vld_q[k] | out_ready_i;
    end else begin : g_mid
      assign rdy[k] = ~vld_q[k] | rdy[k+1];
    end
    assign load_o[k] = rdy[k] & feed[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     vld_q[k] <= 1'b0;
      else if (rdy[k]) vld_q[k] <= feed[k];
    end
  end

  assign in_ready_o = rdy[0];
  assign vld_o      = vld_q;
endmodule

// File: rtl/ycc_to_rgb.sv
module ycc_to_rgb
  import ycc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12,
  parameter int FRAC_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [PIX_W-1:0]     y_i,
  input  logic [PIX_W-1:0]     cb_i,
  input  logic [PIX_W-1:0]     cr_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [PIX_W-1:0]     r_o,
  output logic [PIX_W-1:0]     g_o,
  output logic [PIX_W-1:0]     b_o,
  input  logic                 cfg_we_i,
  input  logic [CFG_SEL_W-1:0] cfg_sel_i,
  input  logic [COEF_W-1:0]    cfg_data_i
);
  localparam int NSTAGE = 3;
  localparam int NCOEF  = 5;
  localparam int DIFF_W = PIX_W + 1;
  localparam int PROD_W = DIFF_W + COEF_W + 1;
  localparam int SUM_W  = PROD_W + 2;
  localparam int CFG_W  = NCOEF * COEF_W + 2 * PIX_W;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

  logic [NCOEF-1:0][COEF_W-1:0] coef;
  logic [PIX_W-1:0]             luma_ofs, chr_ofs;
  logic [NSTAGE-1:0]            load, stage_vld;
  logic                         ctrl_ready, cfg_acc;
  logic [CFG_W-1:0]             cfg_state;

  // config only lands when nothing is in flight
  assign cfg_acc   = cfg_we_i & ~|stage_vld;
  assign cfg_state = {coef, luma_ofs, chr_ofs};

  ycc_cfg_regs #(.PIX_W(PIX_W), .COEF_W(COEF_W), .NCOEF(NCOEF)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (cfg_acc),
    .sel_i      (cfg_sel_i),
    .data_i     (cfg_data_i),
    .coef_o     (coef),
    .luma_ofs_o (luma_ofs),
    .chr_ofs_o  (chr_ofs)
  );

  ycc_pipe_ctrl #(.NSTAGE(NSTAGE)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i & ~cfg_we_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (ctrl_ready),
    .load_o      (load),
    .vld_o       (stage_vld)
  );

  assign in_ready_o  = ctrl_ready & ~cfg_we_i;
  assign out_valid_o = stage_vld[NSTAGE-1];

  // stage 1: offset removal
  logic signed [DIFF_W-1:0] yd_q, cbd_q, crd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      yd_q <= '0; cbd_q <= '0; crd_q <= '0;
    end else if (load[0]) begin
      yd_q  <= $signed({1'b0, y_i})  - $signed({1'b0, luma_ofs});
      cbd_q <= $signed({1'b0, cb_i}) - $signed({1'b0, chr_ofs});
      crd_q <= $signed({1'b0, cr_i}) - $signed({1'b0, chr_ofs});
    end
  end

  // stage 2: products
  logic signed [PROD_W-1:0] p_y_q, p_rv_q, p_gu_q, p_gv_q, p_bu_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_y_q <= '0; p_rv_q <= '0; p_gu_q <= '0; p_gv_q <= '0; p_bu_q <= '0;
    end else if (load[1]) begin
      p_y_q  <= yd_q  * $signed({1'b0, coef[0]});
      p_rv_q <= crd_q * $signed({1'b0, coef[1]});
      p_gu_q <= cbd_q * $signed({1'b0, coef[2]});
      p_gv_q <= crd_q * $signed({1'b0, coef[3]});
      p_bu_q <= cbd_q * $signed({1'b0, coef[4]});
    end
  end

  // stage 3: sum, scale, clip
  function automatic logic [PIX_W-1:0] clip(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] q;
    q = s >>> FRAC_W;
    if (q < 0)         return '0;
    else if (q > MAXV) return '1;
    else               return q[PIX_W-1:0];
  endfunction

  logic signed [SUM_W-1:0] r_sum, g_sum, b_sum;
  assign r_sum = SUM_W'(p_y_q) + SUM_W'(p_rv_q);
  assign g_sum = SUM_W'(p_y_q) - SUM_W'(p_gu_q) - SUM_W'(p_gv_q);
  assign b_sum = SUM_W'(p_y_q) + SUM_W'(p_bu_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_o <= '0; g_o <= '0; b_o <= '0;
    end else if (load[2]) begin
      r_o <= clip(r_sum);
      g_o <= clip(g_sum);
      b_o <= clip(b_sum);
    end
  end
endmodule

module ycc_to_rgb_chk #(
  parameter int PIX_W  = 8,
  parameter int CFG_W  = 76,
  parameter int NSTAGE = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [PIX_W-1:0]  r_o,
  input logic [PIX_W-1:0]  g_o,
  input logic [PIX_W-1:0]  b_o,
  input logic              cfg_we_i,
  input logic [NSTAGE-1:0] stage_vld,
  input logic [CFG_W-1:0]  cfg_state
);
  assert_accept_enters_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> stage_vld[0]);

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable({r_o, g_o, b_o}));

  assert_cfg_blocks_input_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |-> !in_ready_o);

  assert_cfg_only_when_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_state) |-> $past(stage_vld) == '0);

  assert_cfg_needs_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_state) |-> $past(cfg_we_i));
endmodule

bind ycc_to_rgb ycc_to_rgb_chk #(
  .PIX_W  (PIX_W),
  .CFG_W  (CFG_W),
  .NSTAGE (NSTAGE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .r_o         (r_o),
  .g_o         (g_o),
  .b_o         (b_o),
  .cfg_we_i    (cfg_we_i),
  .stage_vld   (stage_vld),
  .cfg_state   (cfg_state)
);

// File: tb/sim_ycc_to_rgb.sv
module sim_ycc_to_rgb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  y_i = '0, cb_i = '0, cr_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [7:0]  r_o, g_o, b_o;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [11:0] cfg_data_i = '0;

  ycc_to_rgb u0 (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic [23:0] rgb;
    int          acc;
    bit          lat;
    string       tag;
  } exp_t;

  exp_t  q[$];
  int    checks = 0, fails = 0, cyc = 0;
  int    pushed = 0, popped = 0;
  int    mk[5];
  int    m_lo, m_co;
  bit    lat_en = 0, bp_en = 0, done = 0;

  initial forever begin @(posedge clk_i); cyc++; end

  function automatic int sat8(input int v);
    int s = v >>> 10;
    if (s < 0) return 0;
    if (s > 255) return 255;
    return s;
  endfunction

  // R2 R3 R4 R5 R6 reference model
  function automatic logic [23:0] model(input int y, input int cb, input int cr);
    int yd = y - m_lo, cbd = cb - m_co, crd = cr - m_co;
    int r = sat8(mk[0]*yd + mk[1]*crd);
    int g = sat8(mk[0]*yd - mk[2]*cbd - mk[3]*crd);
    int b = sat8(mk[0]*yd + mk[4]*cbd);
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input int y, input int cb, input int cr, input string tag);
    exp_t e;
    @(negedge clk_i);
    in_valid_i = 1'b1; y_i = 8'(y); cb_i = 8'(cb); cr_i = 8'(cr);
    #1;
    while (!in_ready_o) begin @(negedge clk_i); #1; end
    e.rgb = model(y, cb, cr); e.acc = cyc + 1; e.lat = lat_en; e.tag = tag;
    q.push_back(e);
    pushed++;
  endtask

  task automatic idle();
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic apply(input int sel, input int data);
    if (sel < 5) mk[sel] = data & 'hFFF;
    else if (sel == 5) m_lo = data & 'hFF;
    else if (sel == 6) m_co = data & 'hFF;
  endtask

  task automatic cfg_write(input int sel, input int data, input bit take);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = 3'(sel); cfg_data_i = 12'(data);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (take) apply(sel, data);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    logic [23:0] held;
    bit stalled = 0;
    forever begin
      @(negedge clk_i); #2;
      if (stalled)
        check("R8 hold", {r_o, g_o, b_o} == held, {r_o, g_o, b_o}, held);
      if (out_valid_o && out_ready_i) begin
        if (q.size() == 0) begin
          check("R8 unexpected output", 1'b0, {r_o, g_o, b_o}, 0);
        end else begin
          e = q.pop_front();
          popped++;
          check(e.tag, {r_o, g_o, b_o} == e.rgb, {r_o, g_o, b_o}, e.rgb);
          if (e.lat) check("R7 latency", cyc - e.acc == 2, cyc - e.acc, 2);
        end
      end
      stalled = out_valid_o && !out_ready_i;
      held = {r_o, g_o, b_o};
    end
  end

  initial forever begin
    @(negedge clk_i);
    if (bp_en) out_ready_i = ($urandom % 4) != 0;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 5; k++) mk[k] = ycc_pkg::def_coef(k);
    m_lo = 0; m_co = 128;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    check("R1 out_valid", out_valid_o == 1'b0, out_valid_o, 0);
    check("R1 in_ready", in_ready_o == 1'b1, in_ready_o, 1);

    // default set
    send(100, 128, 128, "R1");
    send(81, 90, 240, "R1");
    send(145, 54, 34, "R1");
    idle(); drain();

    // colour mix
    send(200, 60, 180, "R3 R4 R5");
    send(30, 200, 50, "R3 R4 R5");
    send(120, 140, 110, "R3 R4 R5");
    send(16, 128, 128, "R3 R4 R5");
    idle(); drain();

    // clipping
    send(255, 255, 255, "R6");
    send(0, 0, 0, "R6");
    send(255, 0, 255, "R6");
    send(0, 255, 0, "R6");
    idle(); drain();

    // offsets
    cfg_write(5, 16, 1);
    cfg_write(6, 100, 1);
    send(10, 90, 250, "R2");
    send(235, 100, 100, "R2");
    send(16, 200, 20, "R2");
    idle(); drain();

    // coefficient writes and an empty select
    cfg_write(0, 'h400, 1);
    cfg_write(1, 'h123, 1);
    cfg_write(2, 'h080, 1);
    cfg_write(3, 'h200, 1);
    cfg_write(4, 'hFFF, 1);
    cfg_write(7, 'h7FF, 0);
    send(80, 150, 170, "R9");
    send(200, 10, 30, "R9");
    idle(); drain();

    // write while a pixel is held in the pipe: must be ignored
    out_ready_i = 1'b0;
    send(90, 140, 120, "R10");
    idle();
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = 3'd0; cfg_data_i = 12'h010;
    in_valid_i = 1'b1;
    #1;
    check("R10 in_ready", in_ready_o == 1'b0, in_ready_o, 0);
    @(negedge clk_i);
    cfg_we_i = 1'b0; in_valid_i = 1'b0;
    out_ready_i = 1'b1;
    drain();
    send(90, 140, 120, "R10");
    idle(); drain();

    // unstalled burst: fixed latency, one per cycle
    lat_en = 1;
    for (int i = 0; i < 24; i++) send((i*11) % 256, (i*37) % 256, (i*53) % 256, "R7");
    idle(); drain();
    lat_en = 0;

    // random backpressure
    bp_en = 1;
    for (int i = 0; i < 200; i++) send($urandom % 256, $urandom % 256, $urandom % 256, "R8");
    idle();
    drain();
    bp_en = 0;
    out_ready_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R8 count", pushed == popped && q.size() == 0, popped, pushed);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule